// File: doc/BRIEF.md
# Broadcast Address Invalidate Translation Cache

This block is a small fully associative cache of translation entries. Each entry holds a virtual page, a physical page, an address-space tag, a virtual-machine tag, a security bit, a stage bit, a final-level bit and a lock bit. A requester searches the cache through a lookup port. A table walker writes new entries through a fill port. Fills go to slots in rotating order, and locked slots are passed over.

The block supports one maintenance command: drop every cached entry that translates a given virtual page, whatever its address-space tag. The command is limited to unlocked, final-level, first-stage entries of the issuer's security regime. When the issuer runs with virtualization enabled, the command is further limited to that issuer's virtual-machine tag. The local core issues the command through a request port with a busy/done handshake, using the current context inputs. Other cores in the same shareability domain broadcast the same command on a snoop port, which carries the sender's context. Each command clears all matching entries in a single cycle. Lookups are held off while a command is in flight.

Top module: `tlbi_bcast_tlb`

## Requirements
- R1: After reset every slot is empty, the fill pointer is at slot 0, and `inv_busy` and `inv_done` are low.
- R2: A lookup hits only on a valid entry whose page equals `lk_vpn`, whose address-space tag equals `lk_asid`, whose final-level and stage bits equal `lk_last` and `lk_stage2`, and whose security bit equals `ctx_secure`. When `ctx_virt_en` is 1 the entry's VM tag must also equal `ctx_vmid`. On a hit, `lk_ppn` returns the entry's physical page in the same cycle.
- R3: In the command operand, bits [31:12] are the virtual page to match and bits [11:0] are ignored. The address-space tag is never compared.
- R4: Only entries with the final-level bit at 1 and the stage bit at 0 (first stage) can be removed. Intermediate-level and second-stage entries survive.
- R5: An entry is removed only if its security bit equals the security state of the command's issuer.
- R6: When the issuer has virtualization enabled, an entry is removed only if its VM tag equals the issuer's VM tag. Otherwise the VM tag is not compared.
- R7: Locked entries are never removed or overwritten.
- R8: A local request is accepted when `inv_req` is high and `inv_busy` is low. `inv_busy` is high in the next cycle, the matching entries are cleared at the end of that cycle, and `inv_done` pulses high for one cycle after that.
- R9: While `inv_busy` is high, `lk_hit` is 0 and `lk_stall` equals `lk_req`.
- R10: A snoop request (`snp_req`) performs the same removal using `snp_secure`, `snp_virt_en` and `snp_vmid`. It is accepted in any cycle, raises `inv_busy`, and produces no `inv_done` pulse.
- R11: When a local request and a snoop arrive together, the local command is applied first. The snoop waits in a one-deep pending slot and is applied in the next cycle, and `inv_busy` stays high until both are done.
- R12: A fill writes the first unlocked slot at or after the rotating pointer, then moves the pointer to the next slot. `fill_lock` locks the new entry. A fill is dropped when every slot is locked. A fill in the same cycle as a removal takes priority for its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_secure | input | 1 | Current security state (1 = secure) |
| ctx_virt_en | input | 1 | Virtualization enabled in the current state |
| ctx_vmid | input | 8 | Current VM tag |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_last | input | 1 | Lookup class: final-level entries |
| lk_stage2 | input | 1 | Lookup class: second-stage entries |
| lk_hit | output | 1 | Lookup hit |
| lk_stall | output | 1 | Lookup held off by a command in flight |
| lk_ppn | output | 20 | Physical page of the hit entry |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 20 | New entry virtual page |
| fill_ppn | input | 20 | New entry physical page |
| fill_asid | input | 8 | New entry address-space tag |
| fill_vmid | input | 8 | New entry VM tag |
| fill_secure | input | 1 | New entry security bit |
| fill_last | input | 1 | New entry final-level bit |
| fill_stage2 | input | 1 | New entry second-stage bit |
| fill_lock | input | 1 | Lock the new entry |
| inv_req | input | 1 | Local removal request |
| inv_op | input | 32 | Local command operand |
| inv_busy | output | 1 | A command is active or pending |
| inv_done | output | 1 | Local command finished (one-cycle pulse) |
| snp_req | input | 1 | Broadcast removal from another core |
| snp_op | input | 32 | Broadcast command operand |
| snp_secure | input | 1 | Sender security state |
| snp_virt_en | input | 1 | Sender virtualization enabled |
| snp_vmid | input | 8 | Sender VM tag |

## Verification
The assertions check on every cycle:
- the handshake timing of the local request;
- that lookups miss while a command is in flight;
- that a waiting snoop becomes active in the next cycle;
- that every slot flagged for removal is empty after the sweep;
- that locked slots persist;
- that the fill victim is always unlocked.

Only the bench's scenarios can show that the matching rules pick the right entries. For every combination of issuer security state, virtualization setting and command source, the bench fills a mixed table and looks up each entry afterwards. The scenarios also show that the reserved operand bits and the address-space tags are ignored, that local and snoop commands are ordered correctly, and that the rotating fill passes over locked slots.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

    parameter int VPN_W  = 20;
    parameter int PPN_W  = 20;
    parameter int ASID_W = 8;
    parameter int VMID_W = 8;
    parameter int OP_W   = 32;
    localparam int OP_LSB = OP_W - VPN_W;

    typedef struct packed {
        logic              valid;
        logic              locked;
        logic              last;
        logic              stage2;
        logic              secure;
        logic [VMID_W-1:0] vmid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic              local_src;
        logic              secure;
        logic              virt_en;
        logic [VMID_W-1:0] vmid;
        logic [VPN_W-1:0]  vpn;
    } inv_cmd_t;

    // Build a command from an operand word; the low reserved bits are dropped.
    function automatic inv_cmd_t make_cmd(input logic is_local, input logic sec,
                                          input logic virt, input logic [VMID_W-1:0] vm,
                                          input logic [OP_W-1:0] op);
        inv_cmd_t c;
        c.local_src = is_local;
        c.secure    = sec;
        c.virt_en   = virt;
        c.vmid      = vm;
        c.vpn       = op[OP_W-1:OP_LSB];
        return c;
    endfunction

    // Removal rule: the address-space tag is deliberately not part of it.
    function automatic logic inv_eligible(input tlb_entry_t e, input inv_cmd_t c);
        logic vm_ok;
        vm_ok = !c.virt_en || (e.vmid == c.vmid);
        return e.valid && !e.locked && e.last && !e.stage2 &&
               (e.secure == c.secure) && vm_ok && (e.vpn == c.vpn);
    endfunction

    function automatic logic lookup_match(input tlb_entry_t e,
                                          input logic [VPN_W-1:0] vpn,
                                          input logic [ASID_W-1:0] asid,
                                          input logic sec, input logic virt,
                                          input logic [VMID_W-1:0] vm,
                                          input logic last, input logic st2);
        logic vm_ok;
        vm_ok = !virt || (e.vmid == vm);
        return e.valid && (e.vpn == vpn) && (e.asid == asid) &&
               (e.secure == sec) && vm_ok && (e.last == last) && (e.stage2 == st2);
    endfunction

endpackage

// File: rtl/tlbi_entry_cmp.sv
module tlbi_entry_cmp
    import tlbi_pkg::*;
(
    input  tlb_entry_t         ent,
    input  inv_cmd_t           cmd,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_secure,
    input  logic               lk_virt_en,
    input  logic [VMID_W-1:0]  lk_vmid,
    input  logic               lk_last,
    input  logic               lk_stage2,
    output logic               inv_hit,
    output logic               lk_match
);

    always_comb begin
        inv_hit  = inv_eligible(ent, cmd);
        lk_match = lookup_match(ent, lk_vpn, lk_asid, lk_secure, lk_virt_en,
                                lk_vmid, lk_last, lk_stage2);
    end

endmodule

// File: rtl/tlbi_cmd_queue.sv
module tlbi_cmd_queue
    import tlbi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     loc_req,
    input  inv_cmd_t loc_cmd,
    input  logic     snp_req,
    input  inv_cmd_t snp_cmd,
    output logic     act_v,
    output inv_cmd_t act_cmd,
    output logic     busy,
    output logic     done
);

    logic     pend_v;
    inv_cmd_t pend_cmd;
    logic     loc_acc;

    assign busy    = act_v | pend_v;
    assign loc_acc = loc_req & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_v    <= 1'b0;
            act_cmd  <= '0;
            pend_v   <= 1'b0;
            pend_cmd <= '0;
            done     <= 1'b0;
        end else begin
            done <= act_v & act_cmd.local_src;
            if (loc_acc) begin
                act_v    <= 1'b1;
                act_cmd  <= loc_cmd;
                pend_v   <= snp_req;
                pend_cmd <= snp_cmd;
            end else if (pend_v) begin
                act_v   <= 1'b1;
                act_cmd <= pend_cmd;
                pend_v  <= snp_req;
                if (snp_req) pend_cmd <= snp_cmd;
            end else if (snp_req) begin
                act_v   <= 1'b1;
                act_cmd <= snp_cmd;
            end else begin
                act_v <= 1'b0;
            end
        end
    end

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        loc_acc |=> busy);
    p_done_two_after_r8: assert property (@(posedge clk) disable iff (rst)
        loc_acc |=> ##1 done);
    p_pending_next_r11: assert property (@(posedge clk) disable iff (rst)
        pend_v |=> (act_v && !act_cmd.local_src));

endmodule

// File: rtl/tlbi_victim_sel.sv
module tlbi_victim_sel #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] lock_vec,
    input  logic               fill_en,
    output logic [IDX_W-1:0]   victim,
    output logic               fill_we
);

    logic [IDX_W-1:0] ptr_q;
    logic             found;

    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int k = 0; k < N_SLOTS; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N_SLOTS) idx = idx - N_SLOTS;
            if (!found && !lock_vec[idx]) begin
                found  = 1'b1;
                victim = IDX_W'(idx);
            end
        end
    end

    assign fill_we = fill_en & found;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_we) begin
            if (int'(victim) == N_SLOTS - 1) ptr_q <= '0;
            else                             ptr_q <= victim + 1'b1;
        end
    end

    p_victim_unlocked_r12: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> !lock_vec[victim]);

endmodule

// File: rtl/tlbi_bcast_tlb.sv
module tlbi_bcast_tlb
    import tlbi_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_secure,
    input  logic              ctx_virt_en,
    input  logic [VMID_W-1:0] ctx_vmid,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_last,
    input  logic              lk_stage2,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic              fill_secure,
    input  logic              fill_last,
    input  logic              fill_stage2,
    input  logic              fill_lock,
    input  logic              inv_req,
    input  logic [OP_W-1:0]   inv_op,
    output logic              inv_busy,
    output logic              inv_done,
    input  logic              snp_req,
    input  logic [OP_W-1:0]   snp_op,
    input  logic              snp_secure,
    input  logic              snp_virt_en,
    input  logic [VMID_W-1:0] snp_vmid
);

    tlb_entry_t             ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0]   lock_vec;
    logic [N_ENTRIES-1:0]   inv_hit;
    logic [N_ENTRIES-1:0]   lk_match;
    logic [IDX_W-1:0]       victim;
    logic                   fill_we;
    logic                   act_v;
    inv_cmd_t               act_cmd;
    inv_cmd_t               loc_cmd;
    inv_cmd_t               snp_cmd;
    tlb_entry_t             new_ent;
    logic                   lk_any;
    logic [PPN_W-1:0]       sel_ppn;

    assign loc_cmd = make_cmd(1'b1, ctx_secure, ctx_virt_en, ctx_vmid, inv_op);
    assign snp_cmd = make_cmd(1'b0, snp_secure, snp_virt_en, snp_vmid, snp_op);

    tlbi_cmd_queue u_queue (
        .clk     (clk),
        .rst     (rst),
        .loc_req (inv_req),
        .loc_cmd (loc_cmd),
        .snp_req (snp_req),
        .snp_cmd (snp_cmd),
        .act_v   (act_v),
        .act_cmd (act_cmd),
        .busy    (inv_busy),
        .done    (inv_done)
    );

    tlbi_victim_sel #(.N_SLOTS(N_ENTRIES)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .lock_vec (lock_vec),
        .fill_en  (fill_en),
        .victim   (victim),
        .fill_we  (fill_we)
    );

    always_comb begin
        new_ent.valid  = 1'b1;
        new_ent.locked = fill_lock;
        new_ent.last   = fill_last;
        new_ent.stage2 = fill_stage2;
        new_ent.secure = fill_secure;
        new_ent.vmid   = fill_vmid;
        new_ent.asid   = fill_asid;
        new_ent.vpn    = fill_vpn;
        new_ent.ppn    = fill_ppn;
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        assign lock_vec[i] = ent_q[i].valid & ent_q[i].locked;

        tlbi_entry_cmp u_cmp (
            .ent        (ent_q[i]),
            .cmd        (act_cmd),
            .lk_vpn     (lk_vpn),
            .lk_asid    (lk_asid),
            .lk_secure  (ctx_secure),
            .lk_virt_en (ctx_virt_en),
            .lk_vmid    (ctx_vmid),
            .lk_last    (lk_last),
            .lk_stage2  (lk_stage2),
            .inv_hit    (inv_hit[i]),
            .lk_match   (lk_match[i])
        );

        // Fill wins over a sweep on the same slot; the sweep clears only valid.
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (fill_we && (victim == IDX_W'(i))) begin
                ent_q[i] <= new_ent;
            end else if (act_v && inv_hit[i]) begin
                ent_q[i].valid <= 1'b0;
            end
        end

        p_locked_kept_r7: assert property (@(posedge clk) disable iff (rst)
            (ent_q[i].valid && ent_q[i].locked) |=> (ent_q[i].valid && ent_q[i].locked));
        p_sweep_clears_r3: assert property (@(posedge clk) disable iff (rst)
            (act_v && inv_hit[i] && !(fill_we && (victim == IDX_W'(i)))) |=> !ent_q[i].valid);
    end

    always_comb begin
        lk_any  = 1'b0;
        sel_ppn = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!lk_any && lk_match[i]) begin
                lk_any  = 1'b1;
                sel_ppn = ent_q[i].ppn;
            end
        end
    end

    assign lk_hit   = lk_req & ~inv_busy & lk_any;
    assign lk_stall = lk_req & inv_busy;
    assign lk_ppn   = lk_hit ? sel_ppn : '0;

    p_stall_miss_r9: assert property (@(posedge clk) disable iff (rst)
        inv_busy |-> !lk_hit);

endmodule

// File: tb/test_tlbi_bcast_tlb.sv
module test_tlbi_bcast_tlb;
    import tlbi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam logic [19:0] TGT = 20'h12345;
    localparam logic [31:0] OPW = {TGT, 12'hABC};

    logic clk = 1'b0;
    logic rst;
    logic ctx_secure, ctx_virt_en;
    logic [7:0] ctx_vmid;
    logic lk_req, lk_last, lk_stage2, lk_hit, lk_stall;
    logic [19:0] lk_vpn, lk_ppn;
    logic [7:0] lk_asid;
    logic fill_en, fill_secure, fill_last, fill_stage2, fill_lock;
    logic [19:0] fill_vpn, fill_ppn;
    logic [7:0] fill_asid, fill_vmid;
    logic inv_req, inv_busy, inv_done;
    logic [31:0] inv_op, snp_op;
    logic snp_req, snp_secure, snp_virt_en;
    logic [7:0] snp_vmid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbi_bcast_tlb i_tlbi_bcast_tlb (
        .clk(clk), .rst(rst),
        .ctx_secure(ctx_secure), .ctx_virt_en(ctx_virt_en), .ctx_vmid(ctx_vmid),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_last(lk_last),
        .lk_stage2(lk_stage2), .lk_hit(lk_hit), .lk_stall(lk_stall), .lk_ppn(lk_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_asid(fill_asid),
        .fill_vmid(fill_vmid), .fill_secure(fill_secure), .fill_last(fill_last),
        .fill_stage2(fill_stage2), .fill_lock(fill_lock),
        .inv_req(inv_req), .inv_op(inv_op), .inv_busy(inv_busy), .inv_done(inv_done),
        .snp_req(snp_req), .snp_op(snp_op), .snp_secure(snp_secure),
        .snp_virt_en(snp_virt_en), .snp_vmid(snp_vmid)
    );

    // Table pattern for slot i.
    function automatic logic [19:0] p_vpn(int i);
        return (i % 4 == 3) ? TGT + 20'(i) : TGT;
    endfunction
    function automatic logic [7:0] p_vmid(int i);
        return ((i >> 1) & 1) != 0 ? 8'd5 : 8'd3;
    endfunction
    function automatic logic p_sec(int i);   return ((i >> 2) & 1) != 0; endfunction
    function automatic logic p_last(int i);  return !(i == 6 || i == 14); endfunction
    function automatic logic p_st2(int i);   return i == 10; endfunction
    function automatic logic p_lock(int i);  return i == 8 || i == 12; endfunction

    function automatic logic removed(int i, logic s, logic v);
        return (p_vpn(i) == TGT) && !p_lock(i) && p_last(i) && !p_st2(i) &&
               (p_sec(i) == s) && (!v || p_vmid(i) == 8'd3);
    endfunction

    function automatic string why(int i, logic s, logic v);
        if (p_vpn(i) != TGT)              return "R3";
        if (!p_last(i) || p_st2(i))       return "R4";
        if (p_lock(i))                    return "R7";
        if (p_sec(i) != s)                return "R5";
        if (v && p_vmid(i) != 8'd3)       return "R6";
        return "R3";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_req = 0; lk_vpn = '0; lk_asid = '0; lk_last = 0; lk_stage2 = 0;
        fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_asid = '0; fill_vmid = '0;
        fill_secure = 0; fill_last = 0; fill_stage2 = 0; fill_lock = 0;
        inv_req = 0; inv_op = '0; snp_req = 0; snp_op = '0;
        snp_secure = 0; snp_virt_en = 0; snp_vmid = '0;
        ctx_secure = 0; ctx_virt_en = 0; ctx_vmid = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic fill_one(logic [19:0] vpn, logic [19:0] ppn, logic [7:0] asid,
                            logic [7:0] vm, logic sec, logic last, logic st2, logic lk);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid; fill_vmid = vm;
        fill_secure = sec; fill_last = last; fill_stage2 = st2; fill_lock = lk;
    endtask

    task automatic fill_pattern();
        for (int i = 0; i < N; i++)
            fill_one(p_vpn(i), 20'h100 + 20'(i), 8'(i), p_vmid(i), p_sec(i),
                     p_last(i), p_st2(i), p_lock(i));
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic probe(string tag, logic [19:0] vpn, logic [7:0] asid, logic [7:0] vm,
                         logic sec, logic last, logic st2, logic exp_hit, logic [19:0] exp_ppn);
        @(negedge clk);
        ctx_secure = sec; ctx_virt_en = 1; ctx_vmid = vm;
        lk_req = 1; lk_vpn = vpn; lk_asid = asid; lk_last = last; lk_stage2 = st2;
        #1;
        check(tag, {31'd0, lk_hit}, {31'd0, exp_hit});
        if (exp_hit) check(tag, {12'd0, lk_ppn}, {12'd0, exp_ppn});
        lk_req = 0;
    endtask

    task automatic probe_slot(int i, logic exp_hit, string tag);
        probe(tag, p_vpn(i), 8'(i), p_vmid(i), p_sec(i), p_last(i), p_st2(i),
              exp_hit, 20'h100 + 20'(i));
    endtask

    task automatic run_scn(logic s, logic v, logic use_snp);
        do_reset();
        fill_pattern();
        @(negedge clk);
        if (use_snp) begin
            snp_req = 1; snp_op = OPW; snp_secure = s; snp_virt_en = v; snp_vmid = 8'd3;
        end else begin
            ctx_secure = s; ctx_virt_en = v; ctx_vmid = 8'd3; inv_op = OPW; inv_req = 1;
        end
        @(negedge clk);
        snp_req = 0; inv_req = 0;
        check("R8 busy during sweep", {31'd0, inv_busy}, 32'd1);
        // R9: lookup on an entry that is present must stall and miss
        ctx_secure = p_sec(15); ctx_virt_en = 1; ctx_vmid = p_vmid(15);
        lk_req = 1; lk_vpn = p_vpn(15); lk_asid = 8'd15; lk_last = 1; lk_stage2 = 0;
        #1;
        check("R9 hit while busy", {31'd0, lk_hit}, 32'd0);
        check("R9 stall while busy", {31'd0, lk_stall}, 32'd1);
        lk_req = 0;
        @(negedge clk);
        if (use_snp) check("R10 no done for snoop", {31'd0, inv_done}, 32'd0);
        else         check("R8 done pulse", {31'd0, inv_done}, 32'd1);
        check("R8 busy cleared", {31'd0, inv_busy}, 32'd0);
        @(negedge clk);
        check("R8 done one cycle", {31'd0, inv_done}, 32'd0);
        for (int i = 0; i < N; i++)
            probe_slot(i, !removed(i, s, v), use_snp ? "R10" : why(i, s, v));
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1;
        idle_inputs();
        do_reset();
        // R1: empty table and idle handshake after reset
        #1;
        check("R1 busy", {31'd0, inv_busy}, 32'd0);
        check("R1 done", {31'd0, inv_done}, 32'd0);
        probe_slot(0, 1'b0, "R1");
        // R2: all filled entries are found with their physical page
        fill_pattern();
        for (int i = 0; i < N; i++) probe_slot(i, 1'b1, "R2");
        probe("R2 asid mismatch", p_vpn(0), 8'd77, p_vmid(0), p_sec(0), 1, 0, 0, '0);
        probe("R2 class mismatch", p_vpn(0), 8'd0, p_vmid(0), p_sec(0), 0, 0, 0, '0);
        probe("R2 vmid mismatch", p_vpn(0), 8'd0, 8'd9, p_sec(0), 1, 0, 0, '0);

        for (int src = 0; src < 2; src++)
            for (int s = 0; s < 2; s++)
                for (int v = 0; v < 2; v++)
                    run_scn(s[0], v[0], src[0]);

        // R11: local and snoop in the same cycle
        do_reset();
        fill_pattern();
        @(negedge clk);
        ctx_secure = 0; ctx_virt_en = 1; ctx_vmid = 8'd3; inv_op = OPW; inv_req = 1;
        snp_req = 1; snp_op = OPW; snp_secure = 1; snp_virt_en = 0; snp_vmid = 8'd0;
        @(negedge clk);
        inv_req = 0; snp_req = 0;
        check("R11 busy first", {31'd0, inv_busy}, 32'd1);
        check("R11 no done yet", {31'd0, inv_done}, 32'd0);
        @(negedge clk);
        check("R11 local done first", {31'd0, inv_done}, 32'd1);
        check("R11 busy for snoop", {31'd0, inv_busy}, 32'd1);
        @(negedge clk);
        check("R11 idle after both", {31'd0, inv_busy}, 32'd0);
        check("R11 single done", {31'd0, inv_done}, 32'd0);
        for (int i = 0; i < N; i++)
            probe_slot(i, !(removed(i, 0, 1) || removed(i, 1, 0)), "R11");

        // R12: second round of fills rotates over the 14 unlocked slots
        do_reset();
        fill_pattern();
        for (int k = 0; k < N; k++)
            fill_one(20'h50000 + 20'(k), 20'h200 + 20'(k), 8'(100 + k), 8'd3, 0, 1, 0, 0);
        @(negedge clk);
        fill_en = 0;
        for (int k = 0; k < N; k++)
            probe("R12 new fill", 20'h50000 + 20'(k), 8'(100 + k), 8'd3, 0, 1, 0,
                  k >= 2, 20'h200 + 20'(k));
        for (int i = 0; i < N; i++)
            probe_slot(i, p_lock(i), "R12");

        finish_up();
    end

endmodule